// File: doc/BRIEF.md
# Guarded Configuration Register Slave

This block is the register front end of a fault-supervision peripheral. It holds a small bank of 32-bit registers that a CPU reaches over a simple single-cycle bus. The bus carries a word index, four byte enables, read/write data and a valid strobe. Every access gets exactly one response one cycle later: a ready pulse, which carries either read data or a transfer-error flag.

The lower part of the bank holds configuration registers, and the upper part holds status registers. Configuration registers can only be modified while the surrounding peripheral reports that it is in its configuration state. A lock command freezes them until reset. Status registers can be written at any time. Reads are always allowed, and no access mode or privilege level is blocked.

The block is strict about access shape. Only a full word, an aligned lower or upper half-word, or a single byte is accepted. Any other byte-enable pattern is answered with an error and changes nothing. So is an index past the end of the bank.

Top module: `gcr_slave`

## Requirements
- R1: A request sampled with `req_valid` high at a clock edge produces `rsp_ready` high for exactly the following cycle. Without a request, `rsp_ready` and `rsp_err` are low and `rsp_rdata` is zero.
- R2: The only accepted `req_be` values are 4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100 and 4'b1000, where bit n enables data bits 8n+7..8n. Every other value, including 4'b0000, three lanes, 4'b0110 and non-adjacent lanes, gives `rsp_err`.
- R3: Word indices 0 to NUM_CFG-1 are configuration registers, and the next NUM_STS indices are status registers. Any higher index gives `rsp_err`.
- R4: A write to a configuration register while `cfg_state` is low gives `rsp_err`.
- R5: `lock_cmd` high at a clock edge locks the bank from the next cycle on. While locked, configuration writes give `rsp_err` even with `cfg_state` high. Only reset clears the lock.
- R6: An access answered with `rsp_err` modifies no register and returns zero on `rsp_rdata`.
- R7: An accepted write updates only the byte lanes whose enables are set, and the other lanes keep their contents.
- R8: An accepted read returns the register's bytes on the enabled lanes and zero on the other lanes. A write response carries zero data.
- R9: Status registers accept writes regardless of `cfg_state` and the lock. Reads of any register in the bank are accepted in every state.
- R10: After reset every register reads zero and the bank is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Word index inside the window |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| cfg_state | input | 1 | Peripheral is in its configuration state |
| lock_cmd | input | 1 | Lock operation, sets the sticky lock |
| rsp_ready | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Transfer error for the answered access |
| rsp_rdata | output | 32 | Read data of the answered access |

## Verification
The assertions assume that requests arrive at most one per cycle and that no request is retried, since each request is answered on its own in the next cycle. They also assume that `cfg_state` and `lock_cmd` are synchronous to `clk`. The stimulus drives every input at the falling edge and holds it for a whole cycle, so each request is sampled exactly once. It draws byte enables from all sixteen patterns and indices from the whole window, including the unused top half. A lock command is issued only after a lock-free phase, so that the behaviour of configuration writes is exercised both before and after the lock is set.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_CFG  = 2'd1,
        CLS_STS  = 2'd2
    } reg_cls_e;
endpackage

// File: rtl/gcr_lane_check.sv
// Accepts only a power-of-two group of lanes sitting on a boundary of its own size.
module gcr_lane_check #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] be,
    output logic             legal
);
    logic [LANES-1:0] pat;

    always_comb begin
        legal = 1'b0;
        pat   = '0;
        for (int sz = 1; sz <= LANES; sz = sz * 2) begin
            for (int off = 0; off < LANES; off = off + sz) begin
                pat = '0;
                for (int b = 0; b < sz; b++) begin
                    pat[off + b] = 1'b1;
                end
                if (be == pat) begin
                    legal = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gcr_decode.sv
module gcr_decode
    import gcr_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_CFG = 4,
    parameter int NUM_STS = 4,
    localparam int NREG   = NUM_CFG + NUM_STS,
    localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output reg_cls_e         cls,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = idx[SEL_W-1:0];
        if (int'(idx) < NUM_CFG) begin
            cls = CLS_CFG;
        end else if (int'(idx) < NREG) begin
            cls = CLS_STS;
        end else begin
            cls = CLS_NONE;
        end
    end
endmodule

// File: rtl/gcr_slave.sv
module gcr_slave
    import gcr_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_CFG = 4,
    parameter int NUM_STS = 4,
    parameter int DATA_W  = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int NREG   = NUM_CFG + NUM_STS,
    localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_state,
    input  logic              lock_cmd,
    output logic              rsp_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        lock;
        logic                        rdy;
        logic                        err;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t q, d;

    logic             be_legal;
    reg_cls_e         cls;
    logic [SEL_W-1:0] sel;
    logic             reject;

    gcr_lane_check #(.LANES(LANES)) u_lanes (
        .be    (req_be),
        .legal (be_legal)
    );

    gcr_decode #(
        .IDX_W   (IDX_W),
        .NUM_CFG (NUM_CFG),
        .NUM_STS (NUM_STS)
    ) u_decode (
        .idx (req_idx),
        .cls (cls),
        .sel (sel)
    );

    always_comb begin
        d       = q;
        d.rdy   = req_valid;
        d.err   = 1'b0;
        d.rdata = '0;
        reject  = !be_legal || (cls == CLS_NONE)
                  || (req_write && (cls == CLS_CFG) && (!cfg_state || q.lock));
        if (lock_cmd) begin
            d.lock = 1'b1;
        end
        if (req_valid) begin
            if (reject) begin
                d.err = 1'b1;
            end else if (req_write) begin
                for (int l = 0; l < LANES; l++) begin
                    if (req_be[l]) begin
                        d.regs[sel][l*8 +: 8] = req_wdata[l*8 +: 8];
                    end
                end
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (req_be[l]) begin
                        d.rdata[l*8 +: 8] = q.regs[sel][l*8 +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_ready = q.rdy;
    assign rsp_err   = q.err;
    assign rsp_rdata = q.rdata;
endmodule

// File: rtl/gcr_checker.sv
module gcr_checker #(
    parameter int IDX_W   = 4,
    parameter int NUM_CFG = 4,
    parameter int NUM_STS = 4,
    parameter int DATA_W  = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int NREG   = NUM_CFG + NUM_STS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W-1:0]  req_idx,
    input logic [LANES-1:0]  req_be,
    input logic              cfg_state,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              lock_q
);
    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready); // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_ready && !rsp_err && rsp_rdata == '0)); // R1
    AST_BAD_LANES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_be == '0 || $countones(req_be) == 3)) |=> rsp_err); // R2
    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_idx) >= NREG) |=> rsp_err); // R3
    AST_CFG_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !cfg_state && int'(req_idx) < NUM_CFG) |=> rsp_err); // R4
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R5
    AST_LOCKED_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && lock_q && int'(req_idx) < NUM_CFG) |=> rsp_err); // R5
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ready && rsp_rdata == '0)); // R6
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == '0); // R8
endmodule

bind gcr_slave gcr_checker #(
    .IDX_W   (IDX_W),
    .NUM_CFG (NUM_CFG),
    .NUM_STS (NUM_STS),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_be    (req_be),
    .cfg_state (cfg_state),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .lock_q    (q.lock)
);

// File: tb/gcr_slave_bench.sv
module gcr_slave_bench;
    localparam int NCFG = 4;
    localparam int NSTS = 4;
    localparam int NREG = NCFG + NSTS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_state = 1'b0;
    logic        lock_cmd = 1'b0;
    logic        rsp_ready;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] mdl [NREG];
    bit m_lock = 1'b0;

    always #2 clk = ~clk;

    gcr_slave u_gcr_slave (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_idx (req_idx), .req_be (req_be), .req_wdata (req_wdata),
        .cfg_state (cfg_state), .lock_cmd (lock_cmd), .rsp_ready (rsp_ready),
        .rsp_err (rsp_err), .rsp_rdata (rsp_rdata)
    );

    function automatic bit be_ok(logic [3:0] be);
        return be == 4'b1111 || be == 4'b0011 || be == 4'b1100 || be == 4'b0001
            || be == 4'b0010 || be == 4'b0100 || be == 4'b1000;
    endfunction

    function automatic bit exp_err(bit w, int idx, logic [3:0] be, bit cfg);
        if (!be_ok(be) || idx >= NREG) return 1'b1;
        if (w && idx < NCFG && (!cfg || m_lock)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        logic [31:0] m = '0;
        for (int l = 0; l < 4; l++) if (be[l]) m[l*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic string tag_of(bit w, int idx, logic [3:0] be, bit cfg);
        if (!be_ok(be)) return "R2";
        if (idx >= NREG) return "R3";
        if (w && idx < NCFG && m_lock) return "R5";
        if (w && idx < NCFG && !cfg) return "R4";
        if (w && idx >= NCFG) return "R9";
        if (w) return "R7";
        return "R8";
    endfunction

    task automatic check(bit ok, string tag, string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic access(bit w, int idx, logic [3:0] be, logic [31:0] wd, bit cfg, bit lk);
        bit e;
        logic [31:0] er;
        string tag;
        e   = exp_err(w, idx, be, cfg);
        er  = (!e && !w && idx < NREG) ? (mdl[idx] & lane_mask(be)) : 32'h0;
        tag = tag_of(w, idx, be, cfg);
        req_valid = 1'b1; req_write = w; req_idx = idx[3:0]; req_be = be;
        req_wdata = wd; cfg_state = cfg; lock_cmd = lk;
        @(negedge clk);
        check(rsp_ready === 1'b1 && rsp_err === e && rsp_rdata === er, tag,
              $sformatf("w=%0b idx=%0d be=%b: got rdy=%b err=%b data=%h, want rdy=1 err=%b data=%h",
                        w, idx, be, rsp_ready, rsp_err, rsp_rdata, e, er));
        if (!e && w) mdl[idx] = (mdl[idx] & ~lane_mask(be)) | (wd & lane_mask(be));
        if (lk) m_lock = 1'b1;
        req_valid = 1'b0; lock_cmd = 1'b0;
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(rsp_ready === 1'b0 && rsp_err === 1'b0 && rsp_rdata === 32'h0, "R1",
              $sformatf("idle: got rdy=%b err=%b data=%h, want 0 0 0", rsp_ready, rsp_err, rsp_rdata));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_ready === 1'b0, "R10", $sformatf("ready after reset got %b want 0", rsp_ready));
        for (int i = 0; i < NREG; i++) access(1'b0, i, 4'b1111, '0, 1'b0, 1'b0); // R10 zeros
        idle_check();

        // R2 directed shapes on a status register
        access(1'b1, NCFG, 4'b0110, 32'hAAAA_AAAA, 1'b0, 1'b0);
        access(1'b1, NCFG, 4'b0000, 32'hAAAA_AAAA, 1'b0, 1'b0);
        access(1'b1, NCFG, 4'b0111, 32'hAAAA_AAAA, 1'b0, 1'b0);
        access(1'b1, NCFG, 4'b1001, 32'hAAAA_AAAA, 1'b0, 1'b0);
        access(1'b0, NCFG, 4'b1111, '0, 1'b0, 1'b0); // R6 nothing written
        // R3 boundary
        access(1'b0, NREG - 1, 4'b1111, '0, 1'b0, 1'b0);
        access(1'b0, NREG, 4'b1111, '0, 1'b0, 1'b0);
        access(1'b1, 15, 4'b1111, 32'h1, 1'b1, 1'b0);
        // R4 and R7
        access(1'b1, 0, 4'b1111, 32'h1122_3344, 1'b0, 1'b0);
        access(1'b1, 0, 4'b1111, 32'h1122_3344, 1'b1, 1'b0);
        access(1'b1, 0, 4'b1100, 32'hFFFF_FFFF, 1'b1, 1'b0);
        access(1'b1, 0, 4'b0010, 32'h0000_5500, 1'b1, 1'b0);
        access(1'b0, 0, 4'b1111, '0, 1'b0, 1'b0);
        access(1'b0, 0, 4'b0100, '0, 1'b0, 1'b0); // R8 masked read
        idle_check();

        for (int n = 0; n < 400; n++) begin
            access(1'($urandom_range(1)), int'($urandom_range(15)), 4'($urandom_range(15)),
                   $urandom, 1'($urandom_range(1)), 1'b0);
            if ($urandom_range(7) == 0) idle_check();
        end

        // R5 lock: issued together with an idle read
        access(1'b0, 1, 4'b1111, '0, 1'b1, 1'b1);
        access(1'b1, 1, 4'b1111, 32'hDEAD_BEEF, 1'b1, 1'b0);
        access(1'b0, 1, 4'b1111, '0, 1'b1, 1'b0);
        access(1'b1, NCFG + 1, 4'b0001, 32'h0000_00C3, 1'b0, 1'b0); // R9
        access(1'b0, NCFG + 1, 4'b1111, '0, 1'b0, 1'b0);

        for (int n = 0; n < 300; n++) begin
            access(1'($urandom_range(1)), int'($urandom_range(15)), 4'($urandom_range(15)),
                   $urandom, 1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        // R10 reset clears the lock and registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_lock = 1'b0;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        access(1'b0, 2, 4'b1111, '0, 1'b0, 1'b0);
        access(1'b1, 2, 4'b1111, 32'h0BAD_F00D, 1'b1, 1'b0);
        access(1'b0, 2, 4'b1111, '0, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule